// File: doc/BRIEF.md
# Bunch-Train Power Sequencer

This block runs the power schedule of a detector front end that only has to listen while the accelerator delivers a train of bunches. The front end is kept off between trains. A train-start pulse switches on the supply enable for the analog front end. The block holds it on for a programmable settle interval, and then opens an acquisition window that spans every bunch crossing of the train. During the window it issues one strobe per crossing, together with a crossing index that the hit logic uses as a time stamp.

After the last crossing the supply stays on for a programmable drain interval so that downstream pipelines can empty. The block then powers down. It ignores new train-start pulses until a programmable hold-off interval has passed.

All intervals are counts of the block clock. At 200 MHz, a 337 ns spacing is 67 cycles, a 60 µs settle lead is 12000 cycles, and 2820 crossings fit in a 12-bit index. Configuration is taken live while the block is idle. It is frozen at the edge that accepts a train, so changes made during a train affect only the next one.

The crossing strobe and index carry no ready signal: crossings follow the beam and cannot be held back. A consumer must accept one index per strobe, and a strobe can come on every cycle when the spacing is one. All other pins are plain level or pulse signals.

Top module: `train_pwr_seq`

## Requirements
- R1: While reset is active, and on the first cycle after it, pwr_en, acq_win, xing_stb and overlap_err are 0 and xing_idx is 0. A reset during a train returns the block to the idle state with power off.
- R2: A train_start that is sampled while the block is idle and its hold-off has elapsed raises pwr_en in the next cycle. The first crossing strobe then follows exactly S cycles after pwr_en rose, where S is cfg_settle.
- R3: acq_win is high for exactly N·P consecutive cycles, where N is cfg_bunches and P is cfg_spacing. xing_stb is high in the first cycle of each P-cycle period of the window, which gives N strobes, and xing_stb is never high outside the window.
- R4: xing_idx is 0 on the first strobe of a train and rises by exactly one on each later strobe. It saturates at N−1 and keeps that value through drain and idle until the next train begins.
- R5: pwr_en stays high for exactly D cycles after acq_win falls, where D is cfg_drain, and then goes low. When D is 0, pwr_en falls together with acq_win.
- R6: After pwr_en falls, a train_start in any of the next H idle cycles is rejected, where H is cfg_holdoff. A train_start in idle cycle H+1 or later is accepted.
- R7: A train_start that arrives while pwr_en is high, or during the hold-off, is ignored: the train in progress keeps its timing. It also produces a one-cycle overlap_err pulse in the following cycle.
- R8: The configuration is sampled only while idle. Values are frozen at the accepting edge, and changes to the configuration inputs during a train do not change that train's settle, window, strobes or drain.
- R9: A value of 0 in cfg_bunches, cfg_spacing or cfg_settle is treated as 1.
- R10: acq_win is never high while pwr_en is low, so power always precedes and covers the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | Train reference pulse, one cycle |
| cfg_bunches | input | 12 | Crossings per train (N) |
| cfg_spacing | input | 16 | Cycles between crossings (P) |
| cfg_settle | input | 16 | Cycles of power before first crossing (S) |
| cfg_drain | input | 8 | Cycles of power after last crossing (D) |
| cfg_holdoff | input | 24 | Idle cycles before a new start is accepted (H) |
| pwr_en | output | 1 | Front-end supply enable |
| acq_win | output | 1 | Acquisition window |
| xing_stb | output | 1 | One-cycle strobe per bunch crossing |
| xing_idx | output | 12 | Crossing index for time stamps |
| overlap_err | output | 1 | One-cycle pulse for a rejected train start |

## Verification
If the phase or index counter is corrupted, it shows up at the next strobe. A missing or doubled strobe, or an index that does not step by one, is visible within a single spacing period. A wrong state or interval count shows up as a wrong length of the settle, window or drain phase, measured in cycles from the rising edge of pwr_en. A wrong hold-off state shows up on the first start pulse after power-down, as either a missing overlap_err or an early pwr_en. The most exposed cases are the ones where counts of one make phases collapse to a single cycle: spacing of one, a single bunch, and drain of zero.

// File: rtl/train_seq_pkg.sv
package train_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WARM  = 2'd1,
    ST_ACQ   = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_cfg_shadow.sv
// Holds the configuration for the running train. While idle the live,
// clamped inputs pass straight through and are captured each cycle.
module seq_cfg_shadow #(
  parameter int BUNCH_W  = 12,
  parameter int SPACE_W  = 16,
  parameter int SETTLE_W = 16,
  parameter int DRAIN_W  = 8,
  parameter int HOLD_W   = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [BUNCH_W-1:0]  bunches_i,
  input  logic [SPACE_W-1:0]  spacing_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [DRAIN_W-1:0]  drain_i,
  input  logic [HOLD_W-1:0]   holdoff_i,
  output logic [BUNCH_W-1:0]  bunches_o,
  output logic [SPACE_W-1:0]  spacing_o,
  output logic [SETTLE_W-1:0] settle_o,
  output logic [DRAIN_W-1:0]  drain_o,
  output logic [HOLD_W-1:0]   holdoff_o
);
  logic [BUNCH_W-1:0]  bun_c, bun_q;
  logic [SPACE_W-1:0]  spc_c, spc_q;
  logic [SETTLE_W-1:0] set_c, set_q;
  logic [DRAIN_W-1:0]  drn_q;
  logic [HOLD_W-1:0]   hld_q;

  // zero counts collapse to one for the fields that form a divisor/phase
  assign bun_c = (bunches_i == '0) ? BUNCH_W'(1)  : bunches_i;
  assign spc_c = (spacing_i == '0) ? SPACE_W'(1)  : spacing_i;
  assign set_c = (settle_i  == '0) ? SETTLE_W'(1) : settle_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bun_q <= BUNCH_W'(1);
      spc_q <= SPACE_W'(1);
      set_q <= SETTLE_W'(1);
      drn_q <= '0;
      hld_q <= '0;
    end else if (load) begin
      bun_q <= bun_c;
      spc_q <= spc_c;
      set_q <= set_c;
      drn_q <= drain_i;
      hld_q <= holdoff_i;
    end
  end

  assign bunches_o = load ? bun_c     : bun_q;
  assign spacing_o = load ? spc_c     : spc_q;
  assign settle_o  = load ? set_c     : set_q;
  assign drain_o   = load ? drain_i   : drn_q;
  assign holdoff_o = load ? holdoff_i : hld_q;
endmodule

// File: rtl/seq_phase_fsm.sv
// Power phase controller: idle with hold-off, warm-up, acquisition, drain.
module seq_phase_fsm
  import train_seq_pkg::*;
#(
  parameter int SETTLE_W = 16,
  parameter int DRAIN_W  = 8,
  parameter int HOLD_W   = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                last_xing_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [DRAIN_W-1:0]  drain_i,
  input  logic [HOLD_W-1:0]   holdoff_i,
  output seq_state_e          state_o,
  output logic                acq_enter_o,
  output logic                reject_o
);
  localparam int CNT_W = (SETTLE_W > DRAIN_W) ? SETTLE_W : DRAIN_W;

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               reject_q;
  logic               accept;

  assign accept      = (state_q == ST_IDLE) && (hold_q == '0);
  assign acq_enter_o = (state_q == ST_WARM) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      hold_q   <= '0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= start_i && !accept;
      unique case (state_q)
        ST_IDLE: begin
          if (hold_q != '0) hold_q <= hold_q - 1'b1;
          if (start_i && accept) begin
            state_q <= ST_WARM;
            cnt_q   <= CNT_W'(settle_i - 1'b1);
          end
        end
        ST_WARM: begin
          if (cnt_q == '0) state_q <= ST_ACQ;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_ACQ: begin
          if (last_xing_i) begin
            if (drain_i == '0) begin
              state_q <= ST_IDLE;
              hold_q  <= holdoff_i;
            end else begin
              state_q <= ST_DRAIN;
              cnt_q   <= CNT_W'(drain_i - 1'b1);
            end
          end
        end
        ST_DRAIN: begin
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            hold_q  <= holdoff_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign reject_o = reject_q;
endmodule

// File: rtl/seq_xing_ctr.sv
// Crossing phase and index counter inside the acquisition window.
module seq_xing_ctr #(
  parameter int BUNCH_W = 12,
  parameter int SPACE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acq_enter_i,
  input  logic               in_acq_i,
  input  logic [BUNCH_W-1:0] bunches_i,
  input  logic [SPACE_W-1:0] spacing_i,
  output logic               stb_o,
  output logic [BUNCH_W-1:0] idx_o,
  output logic               last_xing_o
);
  logic [SPACE_W-1:0] ph_q;
  logic [BUNCH_W-1:0] idx_q;
  logic               period_end;
  logic               at_top;

  assign period_end  = (ph_q == spacing_i - 1'b1);
  assign at_top      = (idx_q == bunches_i - 1'b1);
  assign stb_o       = in_acq_i && (ph_q == '0);
  assign last_xing_o = in_acq_i && period_end && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= '0;
      idx_q <= '0;
    end else if (acq_enter_i) begin
      ph_q  <= '0;
      idx_q <= '0;
    end else if (in_acq_i) begin
      if (period_end) begin
        ph_q <= '0;
        if (!at_top) idx_q <= idx_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/train_pwr_seq.sv
module train_pwr_seq
  import train_seq_pkg::*;
#(
  parameter int BUNCH_W  = 12,
  parameter int SPACE_W  = 16,
  parameter int SETTLE_W = 16,
  parameter int DRAIN_W  = 8,
  parameter int HOLD_W   = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                train_start,
  input  logic [BUNCH_W-1:0]  cfg_bunches,
  input  logic [SPACE_W-1:0]  cfg_spacing,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [DRAIN_W-1:0]  cfg_drain,
  input  logic [HOLD_W-1:0]   cfg_holdoff,
  output logic                pwr_en,
  output logic                acq_win,
  output logic                xing_stb,
  output logic [BUNCH_W-1:0]  xing_idx,
  output logic                overlap_err
);
  seq_state_e          state;
  logic                acq_enter;
  logic                last_xing;
  logic [BUNCH_W-1:0]  bunches_e;
  logic [SPACE_W-1:0]  spacing_e;
  logic [SETTLE_W-1:0] settle_e;
  logic [DRAIN_W-1:0]  drain_e;
  logic [HOLD_W-1:0]   holdoff_e;

  seq_cfg_shadow #(
    .BUNCH_W(BUNCH_W), .SPACE_W(SPACE_W), .SETTLE_W(SETTLE_W),
    .DRAIN_W(DRAIN_W), .HOLD_W(HOLD_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(state == ST_IDLE),
    .bunches_i(cfg_bunches), .spacing_i(cfg_spacing), .settle_i(cfg_settle),
    .drain_i(cfg_drain), .holdoff_i(cfg_holdoff),
    .bunches_o(bunches_e), .spacing_o(spacing_e), .settle_o(settle_e),
    .drain_o(drain_e), .holdoff_o(holdoff_e)
  );

  seq_phase_fsm #(
    .SETTLE_W(SETTLE_W), .DRAIN_W(DRAIN_W), .HOLD_W(HOLD_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(train_start), .last_xing_i(last_xing),
    .settle_i(settle_e), .drain_i(drain_e), .holdoff_i(holdoff_e),
    .state_o(state), .acq_enter_o(acq_enter), .reject_o(overlap_err)
  );

  seq_xing_ctr #(
    .BUNCH_W(BUNCH_W), .SPACE_W(SPACE_W)
  ) xing_i (
    .clk(clk), .rst_n(rst_n), .acq_enter_i(acq_enter),
    .in_acq_i(state == ST_ACQ), .bunches_i(bunches_e), .spacing_i(spacing_e),
    .stb_o(xing_stb), .idx_o(xing_idx), .last_xing_o(last_xing)
  );

  assign pwr_en  = (state != ST_IDLE);
  assign acq_win = (state == ST_ACQ);
endmodule

// File: rtl/train_pwr_seq_chk.sv
module train_pwr_seq_chk #(
  parameter int BUNCH_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               train_start,
  input logic               pwr_en,
  input logic               acq_win,
  input logic               xing_stb,
  input logic [BUNCH_W-1:0] xing_idx,
  input logic               overlap_err
);
  assert_win_in_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acq_win |-> pwr_en);

  assert_power_leads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_win) |-> $past(pwr_en));

  assert_stb_in_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xing_stb |-> acq_win);

  assert_first_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xing_stb && !$past(acq_win)) |-> (xing_idx == '0));

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xing_stb && $past(acq_win)) |-> (xing_idx == $past(xing_idx) + 1'b1));

  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_win |=> (acq_win || $stable(xing_idx)));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |-> $past(train_start));
endmodule

bind train_pwr_seq train_pwr_seq_chk #(.BUNCH_W(BUNCH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .train_start(train_start), .pwr_en(pwr_en),
  .acq_win(acq_win), .xing_stb(xing_stb), .xing_idx(xing_idx),
  .overlap_err(overlap_err)
);

// File: tb/train_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module train_pwr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_start = 1'b0;
  logic [11:0] cfg_bunches = 12'd1;
  logic [15:0] cfg_spacing = 16'd1;
  logic [15:0] cfg_settle  = 16'd1;
  logic [7:0]  cfg_drain   = 8'd0;
  logic [23:0] cfg_holdoff = 24'd2;
  logic        pwr_en, acq_win, xing_stb, overlap_err;
  logic [11:0] xing_idx;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // {bunches, spacing, settle, drain}
  localparam int VEC [6][4] = '{
    '{3, 4, 2, 1},
    '{1, 1, 1, 0},
    '{5, 1, 3, 2},
    '{2, 7, 1, 0},
    '{0, 0, 0, 3},
    '{4, 2, 5, 4}
  };

  always #2.5 clk = ~clk;

  train_pwr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .train_start(train_start),
    .cfg_bunches(cfg_bunches), .cfg_spacing(cfg_spacing),
    .cfg_settle(cfg_settle), .cfg_drain(cfg_drain), .cfg_holdoff(cfg_holdoff),
    .pwr_en(pwr_en), .acq_win(acq_win), .xing_stb(xing_stb),
    .xing_idx(xing_idx), .overlap_err(overlap_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Runs one train; inj>0 pulses train_start at that cycle, scr alters cfg mid-train.
  task automatic run_train(input int vn, input int vp, input int vs, input int vd,
                           input int inj, input bit scr, input bit idle_after);
    int en, ep, es;
    int k, warm, acq, drn, stbs, errs, idxbad;
    bit seen_acq, pwr_first;
    en = (vn == 0) ? 1 : vn;
    ep = (vp == 0) ? 1 : vp;
    es = (vs == 0) ? 1 : vs;
    cfg_bunches = 12'(vn); cfg_spacing = 16'(vp);
    cfg_settle = 16'(vs);  cfg_drain = 8'(vd);
    @(negedge clk);
    train_start = 1'b1;
    k = 0; warm = 0; acq = 0; drn = 0; stbs = 0; errs = 0; idxbad = 0;
    seen_acq = 1'b0; pwr_first = 1'b0;
    while (k < 5000) begin
      @(negedge clk);
      k = k + 1;
      train_start = (k == inj);
      if (scr && k == 2) begin
        cfg_bunches = 12'(vn + 3); cfg_spacing = 16'(vp + 2);
        cfg_settle = 16'(vs + 4);  cfg_drain = 8'(vd + 5);
      end
      if (k == 1) pwr_first = pwr_en;
      if (xing_stb) begin
        if (int'(xing_idx) != stbs) idxbad = idxbad + 1;
        stbs = stbs + 1;
      end
      if (overlap_err) errs = errs + 1;
      if (acq_win) begin acq = acq + 1; seen_acq = 1'b1; end
      else if (pwr_en && !seen_acq) warm = warm + 1;
      else if (pwr_en && seen_acq) drn = drn + 1;
      if (!pwr_en) break;
    end
    train_start = 1'b0;
    chk("R2 pwr_en next cycle", int'(pwr_first), 1);
    chk("R2 settle lead", warm, es);
    chk("R3 window length", acq, en * ep);
    chk("R3 strobe count", stbs, en);
    chk("R4 index per strobe mismatches", idxbad, 0);
    chk("R4 index held after window", int'(xing_idx), en - 1);
    chk("R5 drain length", drn, vd);
    chk("R7 overlap_err pulses", errs, (inj > 0) ? 1 : 0);
    cfg_bunches = 12'(vn); cfg_spacing = 16'(vp);
    cfg_settle = 16'(vs);  cfg_drain = 8'(vd);
    if (idle_after) repeat (int'(cfg_holdoff) + 3) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pwr_en in reset", int'(pwr_en), 0);
    chk("R1 acq_win in reset", int'(acq_win), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwr_en after reset", int'(pwr_en), 0);
    chk("R1 xing_stb after reset", int'(xing_stb), 0);
    chk("R1 xing_idx after reset", int'(xing_idx), 0);
    chk("R1 overlap_err after reset", int'(overlap_err), 0);

    // table-driven trains: R2 R3 R4 R5 R9 (entry 4 uses zeros)
    for (int i = 0; i < 6; i++)
      run_train(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 0, 1'b0, 1'b1);

    // R7 start during warm-up, acquisition and drain
    run_train(2, 2, 4, 1, 2, 1'b0, 1'b1);
    run_train(3, 4, 2, 2, 5, 1'b0, 1'b1);
    run_train(2, 2, 1, 5, 7, 1'b0, 1'b1);

    // R8 configuration changed during the train
    run_train(3, 3, 2, 2, 0, 1'b1, 1'b1);

    // R6 hold-off after power-down (H=6)
    cfg_holdoff = 24'd6;
    @(negedge clk);
    run_train(1, 1, 1, 0, 0, 1'b0, 1'b0);
    train_start = 1'b1;                 // idle cycle 1
    @(negedge clk);
    train_start = 1'b0;
    chk("R6 start in hold-off flagged", int'(overlap_err), 1);
    chk("R6 start in hold-off no power", int'(pwr_en), 0);
    repeat (4) @(negedge clk);          // idle cycle 6
    train_start = 1'b1;
    @(negedge clk);                     // idle cycle 7
    chk("R6 last hold-off cycle flagged", int'(overlap_err), 1);
    chk("R6 last hold-off cycle no power", int'(pwr_en), 0);
    @(negedge clk);
    train_start = 1'b0;
    chk("R6 start after hold-off accepted", int'(pwr_en), 1);
    chk("R6 accepted start not flagged", int'(overlap_err), 0);
    while (pwr_en) @(negedge clk);
    cfg_holdoff = 24'd2;
    repeat (10) @(negedge clk);

    // R1 reset in the middle of a train
    cfg_bunches = 12'd10; cfg_spacing = 16'd5; cfg_settle = 16'd2;
    @(negedge clk);
    train_start = 1'b1;
    @(negedge clk);
    train_start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 window inside power", int'(acq_win & pwr_en), 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-train power off", int'(pwr_en), 0);
    chk("R1 reset mid-train window closed", int'(acq_win), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule